// File: doc/BRIEF.md
# Inverted CAM Address Translator

This block turns a 26-bit logical address into a physical DRAM address. It uses an inverted table. There are 128 entries, and each entry stands for one physical page. An entry records which virtual page number that physical page currently answers to. The block compares the virtual page number of an access against every valid entry in parallel. The position of the single matching entry becomes the physical page number, and the in-page offset is appended to it unchanged. No table lives in memory, and the data bus is never involved. The whole lookup is combinational within the access cycle.

A 2-bit size code selects the page size: 4 KB, 8 KB, 16 KB or 32 KB. The 128 pages therefore cover 512 KB up to 4 MB. The block raises a single abort output in three cases:

- no entry matches (a miss);
- more than one entry matches;
- a user-mode access is refused by the protection level of the matched page.

Software loads entries one per clock through a write port. The port carries an index, a virtual page number and a protection level.

The block holds no state machine. Its only registered state is the entry array (valid bit, page number and protection level per entry). It has two named conditions:

- **Cleared**: the condition after reset, in which every lookup aborts.
- **Loaded**: the condition after a write, in which an entry takes part in lookups from the following cycle.

A write moves an entry from Cleared to Loaded. Writing an entry again while it is Loaded replaces its contents.

Top module: `inv_cam_xlat`

## Requirements
- R1: While reset is held and after it is released, every entry is invalid, so every lookup raises `abort` until an entry is written.
- R2: When `prog_we` is high at a rising clock edge, entry `prog_idx` stores `prog_vpn` and `prog_prot` and becomes valid. Lookups see the new contents from the next cycle.
- R3: The size code `page_sz` selects the page size: 0 is 4 KB, 1 is 8 KB, 2 is 16 KB and 3 is 32 KB. On a single valid match, `pa[18+page_sz:12+page_sz]` equals the index of the matching entry.
- R4: On a hit, `pa[11+page_sz:0]` equals `va[11+page_sz:0]`, and all `pa` bits above bit 18+`page_sz` are zero.
- R5: The lookup compares `va[25:12+page_sz]` with stored `vpn[13:page_sz]`. The stored `vpn` field is aligned to `va[25:12]`, and its low `page_sz` bits are ignored.
- R6: When no valid entry matches, `abort` is 1 and `pa` is 0.
- R7: When two or more valid entries match, `abort` is 1 and `pa` is 0. This includes entries that become equal only because a larger page size masks their low bits.
- R8: With `acc_user` = 1, protection level 0 allows reads and writes, level 1 allows reads only (`acc_write` = 1 aborts), and levels 2 and 3 abort every access. With `acc_user` = 0, every level is allowed.
- R9: `pa` and `abort` follow `va`, `page_sz`, `acc_user` and `acc_write` combinationally, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for entry writes |
| rst | input | 1 | Synchronous active-high reset, clears all valid bits |
| page_sz | input | 2 | Page size code (0: 4 KB, 1: 8 KB, 2: 16 KB, 3: 32 KB) |
| prog_we | input | 1 | Entry write strobe |
| prog_idx | input | 7 | Entry index to write (physical page number) |
| prog_vpn | input | 14 | Virtual page number, aligned to va[25:12] |
| prog_prot | input | 2 | Protection level of the entry |
| va | input | 26 | Logical address of the access |
| acc_user | input | 1 | Access is made in user mode |
| acc_write | input | 1 | Access is a write |
| pa | output | 22 | Physical DRAM address, 0 on abort |
| abort | output | 1 | Miss, multiple match or protection fault |

## Verification
The assertions check these properties on every cycle:

- any non-aborting lookup has exactly one hit;
- the offset passes through and the upper address bits are zero;
- an aborting lookup drives a zero address;
- user writes succeed only on level-0 pages;
- a written entry is valid with the stored page number on the next cycle;
- a multiple-hit count always flags a multiple match;
- the first lookup after reset aborts.

Only the bench scenarios can show the translation values themselves. These include:

- the exact page index returned across all 128 entries at all four page sizes;
- collisions that appear only when a larger page size masks the low page bits;
- the full protection table;
- lookups that change between clock edges.

// File: rtl/ict_pkg.sv
package ict_pkg;

    localparam int LA_W      = 26;
    localparam int MIN_SHIFT = 12;
    localparam int SZ_CODES  = 4;
    localparam int SZ_W      = $clog2(SZ_CODES);
    localparam int VPN_W     = LA_W - MIN_SHIFT;
    localparam int PROT_W    = 2;

    typedef enum logic [PROT_W-1:0] {
        PROT_USER_RW = 2'd0,
        PROT_USER_RO = 2'd1,
        PROT_SUPV_A  = 2'd2,
        PROT_SUPV_B  = 2'd3
    } prot_e;

    typedef enum logic [SZ_W-1:0] {
        PG_4K  = 2'd0,
        PG_8K  = 2'd1,
        PG_16K = 2'd2,
        PG_32K = 2'd3
    } pgsz_e;

endpackage

// File: rtl/ict_entry.sv
module ict_entry
    import ict_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PROT_W-1:0] wr_prot,
    input  logic [VPN_W-1:0]  cmp_vpn,
    input  logic [VPN_W-1:0]  cmp_mask,
    output logic              hit,
    output logic [PROT_W-1:0] prot
);

    logic             valid_q;
    logic [VPN_W-1:0] vpn_q;
    logic [PROT_W-1:0] prot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            vpn_q   <= '0;
            prot_q  <= '0;
        end else if (wr_en) begin
            valid_q <= 1'b1;
            vpn_q   <= wr_vpn;
            prot_q  <= wr_prot;
        end
    end

    always_comb begin
        hit  = valid_q && (((vpn_q ^ cmp_vpn) & cmp_mask) == '0);
        prot = prot_q;
    end

    // R2
    entry_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (valid_q && vpn_q == $past(wr_vpn) && prot_q == $past(wr_prot)));

endmodule

// File: rtl/ict_match_enc.sv
module ict_match_enc
    import ict_pkg::*;
#(
    parameter int ENTRIES = 128,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [ENTRIES-1:0]              hits,
    input  logic [ENTRIES-1:0][PROT_W-1:0]  prots,
    output logic [IDX_W-1:0]                idx,
    output logic [PROT_W-1:0]               sel_prot,
    output logic                            any_hit,
    output logic                            multi
);

    always_comb begin
        logic seen;
        seen     = 1'b0;
        multi    = 1'b0;
        idx      = '0;
        sel_prot = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hits[i]) begin
                if (seen) multi = 1'b1;
                seen     = 1'b1;
                idx      = idx | IDX_W'(i);
                sel_prot = sel_prot | prots[i];
            end
        end
        any_hit = seen;
    end

    // R7
    multi_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(hits) > 1) |-> multi);

endmodule

// File: rtl/inv_cam_xlat.sv
module inv_cam_xlat
    import ict_pkg::*;
#(
    parameter int ENTRIES = 128,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int PA_W   = IDX_W + MIN_SHIFT + SZ_CODES - 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SZ_W-1:0]    page_sz,
    input  logic               prog_we,
    input  logic [IDX_W-1:0]   prog_idx,
    input  logic [VPN_W-1:0]   prog_vpn,
    input  logic [PROT_W-1:0]  prog_prot,
    input  logic [LA_W-1:0]    va,
    input  logic               acc_user,
    input  logic               acc_write,
    output logic [PA_W-1:0]    pa,
    output logic               abort
);

    logic [VPN_W-1:0]                cmp_mask;
    logic [PA_W-1:0]                 off_mask;
    logic [ENTRIES-1:0]              hit_vec;
    logic [ENTRIES-1:0][PROT_W-1:0]  prot_vec;
    logic [IDX_W-1:0]                hit_idx;
    logic [PROT_W-1:0]               hit_prot;
    logic                            any_hit;
    logic                            multi_hit;
    logic                            prot_fault;

    always_comb begin
        cmp_mask = ~((VPN_W'(1) << page_sz) - VPN_W'(1));
        off_mask = (PA_W'(1) << (MIN_SHIFT + int'(page_sz))) - PA_W'(1);
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        ict_entry u_ent (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (prog_we && (prog_idx == IDX_W'(g))),
            .wr_vpn  (prog_vpn),
            .wr_prot (prog_prot),
            .cmp_vpn (va[LA_W-1:MIN_SHIFT]),
            .cmp_mask(cmp_mask),
            .hit     (hit_vec[g]),
            .prot    (prot_vec[g])
        );
    end

    ict_match_enc #(.ENTRIES(ENTRIES)) u_enc (
        .clk     (clk),
        .rst     (rst),
        .hits    (hit_vec),
        .prots   (prot_vec),
        .idx     (hit_idx),
        .sel_prot(hit_prot),
        .any_hit (any_hit),
        .multi   (multi_hit)
    );

    always_comb begin
        prot_fault = 1'b0;
        if (acc_user) begin
            unique case (prot_e'(hit_prot))
                PROT_USER_RW: prot_fault = 1'b0;
                PROT_USER_RO: prot_fault = acc_write;
                PROT_SUPV_A,
                PROT_SUPV_B:  prot_fault = 1'b1;
            endcase
        end
        abort = !any_hit || multi_hit || prot_fault;
        if (abort)
            pa = '0;
        else
            pa = ((PA_W'(hit_idx)) << (MIN_SHIFT + int'(page_sz)))
               | (va[PA_W-1:0] & off_mask);
    end

    // R1
    reset_abort_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> abort);

    // R7
    hit_unique_chk: assert property (@(posedge clk) disable iff (rst)
        !abort |-> $onehot(hit_vec));

    // R4
    offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !abort |-> (((pa ^ va[PA_W-1:0]) & off_mask) == '0 &&
                    (pa >> (MIN_SHIFT + IDX_W + int'(page_sz))) == '0));

    // R6
    pa_zero_chk: assert property (@(posedge clk) disable iff (rst)
        abort |-> (pa == '0));

    // R8
    prot_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!abort && acc_user && acc_write) |-> (prot_vec[hit_idx] == PROT_USER_RW));

endmodule

// File: tb/inv_cam_xlat_tb_top.sv
module inv_cam_xlat_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  page_sz = '0;
    logic        prog_we = 1'b0;
    logic [6:0]  prog_idx = '0;
    logic [13:0] prog_vpn = '0;
    logic [1:0]  prog_prot = '0;
    logic [25:0] va = '0;
    logic        acc_user = 1'b0;
    logic        acc_write = 1'b0;
    logic [21:0] pa;
    logic        abort;

    int checks = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    inv_cam_xlat dut_i (
        .clk(clk), .rst(rst), .page_sz(page_sz), .prog_we(prog_we),
        .prog_idx(prog_idx), .prog_vpn(prog_vpn), .prog_prot(prog_prot),
        .va(va), .acc_user(acc_user), .acc_write(acc_write),
        .pa(pa), .abort(abort)
    );

    function automatic logic [13:0] perm_vpn(int i);
        return 14'(((i * 29 + 3) % 128) << 3);
    endfunction

    task automatic check(string req, logic [21:0] exp_pa, logic exp_ab);
        checks++;
        if (pa !== exp_pa || abort !== exp_ab) begin
            bad++;
            $display("FAIL %s: pa=%h abort=%b expected pa=%h abort=%b",
                     req, pa, abort, exp_pa, exp_ab);
        end
    endtask

    task automatic write_ent(int idx, logic [13:0] vpn, logic [1:0] prot);
        @(negedge clk);
        prog_we = 1'b1; prog_idx = 7'(idx); prog_vpn = vpn; prog_prot = prot;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic look(logic [1:0] sz, logic [25:0] addr, logic usr, logic wr);
        page_sz = sz; va = addr; acc_user = usr; acc_write = wr;
        #1;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; bad++;
            $display("FAIL watchdog: run did not complete");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: lookup during reset and after release, nothing programmed
        look(2'd0, 26'h0, 1'b0, 1'b0);
        check("R1", '0, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        for (int s = 0; s < 4; s++) begin
            look(2'(s), {perm_vpn(7), 12'h0}, 1'b0, 1'b0);
            check("R1", '0, 1'b1);
        end

        // R2: load all entries, one per clock
        for (int i = 0; i < 128; i++) write_ent(i, perm_vpn(i), 2'd0);

        // R3 R4 R5: full sweep at every page size
        for (int s = 0; s < 4; s++) begin
            for (int i = 0; i < 128; i++) begin
                logic [25:0] off;
                logic [25:0] omask;
                omask = (26'd1 << (12 + s)) - 26'd1;
                off = 26'((i * 2654435 + s * 977) & 32'h7fff) & omask;
                look(2'(s), ({perm_vpn(i), 12'h0}) | off, 1'b0, 1'b0);
                check("R3/R4/R5", (22'(i) << (12 + s)) | 22'(off), 1'b0);
            end
        end

        // R6: miss on an unused page number
        look(2'd0, {14'h1000, 12'h123}, 1'b0, 1'b0);
        check("R6", '0, 1'b1);
        look(2'd3, {14'h2000, 12'hfff}, 1'b0, 1'b0);
        check("R6", '0, 1'b1);

        // R9: two changes of va between clock edges
        @(negedge clk);
        look(2'd0, {perm_vpn(40), 12'h0ab}, 1'b0, 1'b0);
        check("R9", (22'd40 << 12) | 22'h0ab, 1'b0);
        look(2'd0, {perm_vpn(41), 12'h0cd}, 1'b0, 1'b0);
        check("R9", (22'd41 << 12) | 22'h0cd, 1'b0);

        // R7: duplicate page number
        write_ent(20, perm_vpn(21), 2'd0);
        look(2'd0, {perm_vpn(21), 12'h0}, 1'b0, 1'b0);
        check("R7", '0, 1'b1);
        look(2'd0, {perm_vpn(20), 12'h0}, 1'b0, 1'b0);
        check("R6", '0, 1'b1);

        // R5 R7: entries distinct at 4 KB, colliding at 8 KB
        write_ent(30, 14'h2000, 2'd0);
        write_ent(31, 14'h2001, 2'd0);
        look(2'd0, {14'h2001, 12'h456}, 1'b0, 1'b0);
        check("R5", (22'd31 << 12) | 22'h456, 1'b0);
        look(2'd0, {14'h2000, 12'h456}, 1'b0, 1'b0);
        check("R5", (22'd30 << 12) | 22'h456, 1'b0);
        look(2'd1, {14'h2001, 12'h456}, 1'b0, 1'b0);
        check("R7", '0, 1'b1);

        // R8: protection table
        for (int lv = 0; lv < 4; lv++) begin
            write_ent(10, perm_vpn(10), 2'(lv));
            for (int u = 0; u < 2; u++) begin
                for (int w = 0; w < 2; w++) begin
                    logic ab;
                    ab = (u == 1) && (lv >= 2 || (lv == 1 && w == 1));
                    look(2'd0, {perm_vpn(10), 12'h3a5}, 1'(u), 1'(w));
                    check("R8", ab ? 22'd0 : ((22'd10 << 12) | 22'h3a5), ab);
                end
            end
        end

        // R2: rewrite moves an entry to a new page number
        write_ent(50, 14'h3f00, 2'd0);
        look(2'd2, {14'h3f00, 12'h777}, 1'b0, 1'b0);
        check("R2", (22'd50 << 14) | 22'h0777, 1'b0);
        look(2'd2, {perm_vpn(50), 12'h0}, 1'b0, 1'b0);
        check("R2", '0, 1'b1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule